// File: doc/BRIEF.md
# Checker Stage Self-Test Sequencer

This block holds the execute-check stage of an instruction checker together with a self-test sequencer for it. In normal operation the stage latches one retiring instruction per cycle from the core: an operation code, two operand values and the core's predicted result. It recomputes the result and raises an error flag when the prediction is wrong. A stall input freezes the stage latch.

A start pulse puts the block into self-test. A mux in front of the stage latch then selects entries from a constant vector table instead of the core inputs, one entry per non-stalled cycle. Each entry carries an operation, operands, a predicted result and an expected-error bit. Some entries hold deliberately corrupted predictions, so both the pass and the fail sides of the compare logic are exercised. The stage's own error flag is the test response. Any entry whose flag disagrees with its expected-error bit sets a sticky fail flag and records the index of the first such entry.

After the vectors, a march test runs over a small scratch memory. Once both phases have finished, the block holds `done` until the next start.

Top module: `chkbist_top`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `mem_fail` and `chk_valid` are low and `fail_idx` is zero.
- R2: In normal mode, an item presented with `core_valid` high on a non-stalled cycle appears on `chk_valid` after the next clock. `chk_err` is high exactly when `core_pred` differs from the recomputed result. The operation codes are: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift A left by B[3:0], 6 shift A right logically by B[3:0], 7 pass B. All are modulo 2^16.
- R3: While `stall` is high, the stage latch holds its contents, so `chk_valid` and `chk_err` do not change at the next clock.
- R4: A start pulse while idle or done raises `busy` at the next clock. The block takes 16 table entries, one per non-stalled cycle. It then needs one further non-stalled cycle for the final compare, followed by 3*MEM_DEPTH cycles of march. After that, `busy` falls and `done` rises.
- R5: While `busy` is high, the core inputs are not latched. `chk_valid` is low whenever the previous non-stalled clock happened during `busy`.
- R6: A start pulse while `busy` is high has no effect on the sequence or its timing.
- R7: The vector table holds 12 correct and 4 corrupted predictions. `fail` is set only when a latched entry's error flag differs from its expected-error bit. On a correct stage, `fail` stays low and `fail_idx` stays 0 through the whole run. `fail` stays set until the next start.
- R8: The march writes zeros at all addresses. It then goes up the addresses reading zero and writing ones, and then down the addresses reading ones and writing zero. Any mismatched read sets `mem_fail`, which is cleared when the march begins. On a correct memory, `mem_fail` stays low.
- R9: `done` holds until a start pulse arrives. That pulse clears `fail` and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Self-test start pulse |
| stall | input | 1 | Stage stall; holds the stage latch |
| core_valid | input | 1 | Core item present |
| core_op | input | 3 | Core operation code |
| core_a | input | 16 | Core operand A |
| core_b | input | 16 | Core operand B |
| core_pred | input | 16 | Core predicted result |
| chk_valid | output | 1 | Latched core item valid |
| chk_err | output | 1 | Latched core item has a wrong prediction |
| busy | output | 1 | Self-test running |
| done | output | 1 | Self-test finished |
| fail | output | 1 | Sticky vector-compare failure |
| fail_idx | output | 4 | Index of first failing vector |
| mem_fail | output | 1 | Sticky march read mismatch |

## Verification
Normal-mode traffic cycles through every operation code with both correct and flipped predictions. This shows that the error flag separates right results from wrong ones for each operation, and stall bursts in that traffic separate holding from advancing. A self-test run with junk core traffic and stray start pulses during `busy` shows whether the mux really overrides the core and whether restarts are masked. A second run, started from `done` under a recurring stall, shows whether only non-stalled cycles advance the vector phase while the march keeps fixed timing. The bench's cycle model predicts `busy` and `done` every clock, and a clean `fail` at the end shows that corrupted entries were flagged exactly as expected.

// File: rtl/chkbist_pkg.sv
package chkbist_pkg;
   localparam int DW   = 16;
   localparam int NVEC = 16;
   localparam int IXW  = $clog2(NVEC);

   typedef enum logic [2:0] {
      OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
      OP_XOR = 3'd4, OP_SLL = 3'd5, OP_SRL = 3'd6, OP_PSB = 3'd7
   } op_e;

   typedef struct packed {
      op_e           op;
      logic [DW-1:0] a;
      logic [DW-1:0] b;
      logic [DW-1:0] pred;
      logic          xfail;
   } vec_t;

   function automatic logic [DW-1:0] alu_eval(op_e op, logic [DW-1:0] a, logic [DW-1:0] b);
      case (op)
         OP_ADD:  return a + b;
         OP_SUB:  return a - b;
         OP_AND:  return a & b;
         OP_OR:   return a | b;
         OP_XOR:  return a ^ b;
         OP_SLL:  return a << b[3:0];
         OP_SRL:  return a >> b[3:0];
         default: return b;
      endcase
   endfunction

   function automatic vec_t mk(op_e op, logic [DW-1:0] a, logic [DW-1:0] b,
                               logic [DW-1:0] p, logic x);
      vec_t v;
      v.op = op; v.a = a; v.b = b; v.pred = p; v.xfail = x;
      return v;
   endfunction

   // constant vector table; entries 10, 11, 13, 15 carry corrupted predictions
   function automatic vec_t rom_entry(logic [IXW-1:0] i);
      case (i)
         4'd0:  return mk(OP_ADD, 16'h1234, 16'h0F0F, 16'h2143, 1'b0);
         4'd1:  return mk(OP_ADD, 16'hFFFF, 16'h0001, 16'h0000, 1'b0);
         4'd2:  return mk(OP_SUB, 16'h1000, 16'h0001, 16'h0FFF, 1'b0);
         4'd3:  return mk(OP_SUB, 16'h0000, 16'h0001, 16'hFFFF, 1'b0);
         4'd4:  return mk(OP_AND, 16'hF0F0, 16'h3C3C, 16'h3030, 1'b0);
         4'd5:  return mk(OP_OR,  16'hF000, 16'h000F, 16'hF00F, 1'b0);
         4'd6:  return mk(OP_XOR, 16'hAAAA, 16'hFFFF, 16'h5555, 1'b0);
         4'd7:  return mk(OP_SLL, 16'h0001, 16'h0004, 16'h0010, 1'b0);
         4'd8:  return mk(OP_SRL, 16'h8000, 16'h000F, 16'h0001, 1'b0);
         4'd9:  return mk(OP_PSB, 16'h1111, 16'hBEEF, 16'hBEEF, 1'b0);
         4'd10: return mk(OP_ADD, 16'h0001, 16'h0001, 16'h0003, 1'b1);
         4'd11: return mk(OP_SUB, 16'h5555, 16'h5555, 16'h0001, 1'b1);
         4'd12: return mk(OP_AND, 16'hFFFF, 16'h00FF, 16'h00FF, 1'b0);
         4'd13: return mk(OP_XOR, 16'h1234, 16'h1234, 16'h8000, 1'b1);
         4'd14: return mk(OP_SLL, 16'h00FF, 16'h0008, 16'hFF00, 1'b0);
         default: return mk(OP_SRL, 16'h00FF, 16'h0004, 16'h0F0F, 1'b1);
      endcase
   endfunction
endpackage

// File: rtl/chkbist_rom.sv
module chkbist_rom
   import chkbist_pkg::*;
(
   input  logic [IXW-1:0] idx,
   output vec_t           vec
);
   assign vec = rom_entry(idx);
endmodule

// File: rtl/chkbist_exec_stage.sv
module chkbist_exec_stage
   import chkbist_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stall,
   input  logic          sel_tst,
   input  logic          tst_vld,
   input  vec_t          tst_vec,
   input  logic          core_vld,
   input  logic [2:0]    core_op,
   input  logic [DW-1:0] core_a,
   input  logic [DW-1:0] core_b,
   input  logic [DW-1:0] core_pred,
   output logic          lat_vld,
   output logic          lat_tst,
   output logic          lat_err,
   output logic          lat_xfail
);
   vec_t lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_vld <= 1'b0;
         lat_tst <= 1'b0;
         lat_q   <= '0;
      end else if (!stall) begin
         if (sel_tst) begin
            lat_vld <= tst_vld;
            lat_tst <= 1'b1;
            lat_q   <= tst_vec;
         end else begin
            lat_vld <= core_vld;
            lat_tst <= 1'b0;
            lat_q   <= mk(op_e'(core_op), core_a, core_b, core_pred, 1'b0);
         end
      end
   end

   assign lat_err   = lat_vld && (alu_eval(lat_q.op, lat_q.a, lat_q.b) != lat_q.pred);
   assign lat_xfail = lat_q.xfail;
endmodule

// File: rtl/chkbist_march.sv
module chkbist_march #(
   parameter int DEPTH = 16,
   parameter int MW    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic last,
   output logic mem_fail
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW-1:0] ATOP = AW'(DEPTH - 1);

   typedef enum logic [1:0] {M_IDLE, M_WZ, M_UP, M_DN} mph_e;

   mph_e            ph;
   logic [AW-1:0]   addr;
   logic [MW-1:0]   mem [DEPTH];
   logic [MW-1:0]   rd;
   logic            mism;

   assign rd   = mem[addr];
   assign mism = ((ph == M_UP) && (rd != '0)) || ((ph == M_DN) && (rd != '1));
   assign last = (ph == M_DN) && (addr == '0);

   always_ff @(posedge clk) begin
      if (ph != M_IDLE) mem[addr] <= (ph == M_UP) ? '1 : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph       <= M_IDLE;
         addr     <= '0;
         mem_fail <= 1'b0;
      end else begin
         if (mism) mem_fail <= 1'b1;
         case (ph)
            M_IDLE: if (go) begin
               ph       <= M_WZ;
               addr     <= '0;
               mem_fail <= 1'b0;
            end
            M_WZ: if (addr == ATOP) begin ph <= M_UP; addr <= '0; end
                  else addr <= addr + 1'b1;
            M_UP: if (addr == ATOP) ph <= M_DN;
                  else addr <= addr + 1'b1;
            default: if (addr == '0) ph <= M_IDLE;
                     else addr <= addr - 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/chkbist_top.sv
module chkbist_top
   import chkbist_pkg::*;
#(
   parameter int MEM_DEPTH = 16,
   parameter int MEM_W     = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           stall,
   input  logic           core_valid,
   input  logic [2:0]     core_op,
   input  logic [DW-1:0]  core_a,
   input  logic [DW-1:0]  core_b,
   input  logic [DW-1:0]  core_pred,
   output logic           chk_valid,
   output logic           chk_err,
   output logic           busy,
   output logic           done,
   output logic           fail,
   output logic [IXW-1:0] fail_idx,
   output logic           mem_fail
);
   localparam logic [IXW:0] IDX_END = (IXW+1)'(NVEC);

   generate
      if (MEM_DEPTH < 2 || (MEM_DEPTH & (MEM_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("MEM_DEPTH must be a power of two of at least 2");
      end
      if (MEM_W < 1) begin : g_bad_width
         $error("MEM_W must be positive");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_VEC, S_MARCH, S_FIN} st_e;

   st_e            st;
   logic [IXW:0]   idx;
   logic [IXW-1:0] lidx;
   vec_t           rom_vec;
   logic           tst_vld, lat_vld, lat_tst, lat_err, lat_xfail;
   logic           m_go, m_last;

   assign busy    = (st == S_VEC) || (st == S_MARCH);
   assign done    = (st == S_FIN);
   assign tst_vld = (st == S_VEC) && (idx != IDX_END);
   assign m_go    = (st == S_VEC) && (idx == IDX_END) && !stall;

   chkbist_rom u_rom (.idx(idx[IXW-1:0]), .vec(rom_vec));

   chkbist_exec_stage u_stage (
      .clk(clk), .rst_n(rst_n), .stall(stall), .sel_tst(busy),
      .tst_vld(tst_vld), .tst_vec(rom_vec),
      .core_vld(core_valid), .core_op(core_op), .core_a(core_a),
      .core_b(core_b), .core_pred(core_pred),
      .lat_vld(lat_vld), .lat_tst(lat_tst), .lat_err(lat_err), .lat_xfail(lat_xfail)
   );

   chkbist_march #(.DEPTH(MEM_DEPTH), .MW(MEM_W)) u_march (
      .clk(clk), .rst_n(rst_n), .go(m_go), .last(m_last), .mem_fail(mem_fail)
   );

   assign chk_valid = lat_vld && !lat_tst;
   assign chk_err   = chk_valid && lat_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         idx      <= '0;
         lidx     <= '0;
         fail     <= 1'b0;
         fail_idx <= '0;
      end else begin
         case (st)
            S_VEC: if (!stall) begin
               if (lat_vld && lat_tst && (lat_err != lat_xfail) && !fail) begin
                  fail     <= 1'b1;
                  fail_idx <= lidx;
               end
               if (idx == IDX_END) st <= S_MARCH;
               else begin
                  lidx <= idx[IXW-1:0];
                  idx  <= idx + 1'b1;
               end
            end
            S_MARCH: if (m_last) st <= S_FIN;
            default: if (start) begin
               st       <= S_VEC;
               idx      <= '0;
               fail     <= 1'b0;
               fail_idx <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/chkbist_top_chk.sv
module chkbist_top_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic stall,
   input logic busy,
   input logic done,
   input logic fail,
   input logic mem_fail,
   input logic chk_valid,
   input logic chk_err
);
   // R4
   busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   // R9
   done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);
   // R3
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(chk_valid) && $stable(chk_err));
   // R5
   core_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) && !$past(stall) |-> !chk_valid);
   // R7
   fail_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> busy || done);
   // R8
   memfail_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_fail) |-> busy || done);
endmodule

bind chkbist_top chkbist_top_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .stall(stall), .busy(busy),
   .done(done), .fail(fail), .mem_fail(mem_fail),
   .chk_valid(chk_valid), .chk_err(chk_err)
);

// File: tb/chkbist_top_bench.sv
module chkbist_top_bench;
   localparam int MD = 16;
   localparam int NV = 16;
   localparam int S_IDLE = 0, S_VEC = 1, S_MARCH = 2, S_FIN = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, stall = 1'b0, core_valid = 1'b0;
   logic [2:0]  core_op = '0;
   logic [15:0] core_a = '0, core_b = '0, core_pred = '0;
   logic        chk_valid, chk_err, busy, done, fail, mem_fail;
   logic [3:0]  fail_idx;

   int checks = 0, errors = 0;
   int m_state = S_IDLE, m_cnt = 0;
   bit m_vld = 0, m_err = 0, m_prev_stall = 0;
   int unsigned seed = 32'h1A2B3C4D;

   always #5 clk = ~clk;

   chkbist_top #(.MEM_DEPTH(MD), .MEM_W(8)) u_chkbist_top (
      .clk(clk), .rst_n(rst_n), .start(start), .stall(stall),
      .core_valid(core_valid), .core_op(core_op), .core_a(core_a),
      .core_b(core_b), .core_pred(core_pred),
      .chk_valid(chk_valid), .chk_err(chk_err), .busy(busy), .done(done),
      .fail(fail), .fail_idx(fail_idx), .mem_fail(mem_fail)
   );

   function automatic logic [15:0] ref_alu(int op, logic [15:0] a, logic [15:0] b);
      case (op)
         0: return a + b;
         1: return a - b;
         2: return a & b;
         3: return a | b;
         4: return a ^ b;
         5: return a << b[3:0];
         6: return a >> b[3:0];
         default: return b;
      endcase
   endfunction

   function automatic logic [15:0] rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed[23:8];
   endfunction

   // behavioural reference, advanced on every clock
   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = S_IDLE; m_cnt = 0; m_vld = 0; m_err = 0; m_prev_stall = 0;
      end else begin
         bit was_busy;
         was_busy = (m_state == S_VEC) || (m_state == S_MARCH);
         if (!stall) begin
            m_vld = !was_busy && core_valid;
            m_err = ref_alu(int'(core_op), core_a, core_b) != core_pred;
         end
         m_prev_stall = stall;
         case (m_state)
            S_VEC: if (!stall) begin
               m_cnt--;
               if (m_cnt == 0) begin m_state = S_MARCH; m_cnt = 3 * MD; end
            end
            S_MARCH: begin
               m_cnt--;
               if (m_cnt == 0) m_state = S_FIN;
            end
            default: if (start) begin m_state = S_VEC; m_cnt = NV + 1; end
         endcase
      end
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit mb;
      mb = (m_state == S_VEC) || (m_state == S_MARCH);
      chk(busy == mb, "R4 busy", busy, mb);
      chk(done == (m_state == S_FIN), "R9 done", done, m_state == S_FIN);
      chk(fail == 1'b0, "R7 fail", fail, 0);
      chk(fail_idx == 4'd0, "R7 fail_idx", fail_idx, 0);
      chk(mem_fail == 1'b0, "R8 mem_fail", mem_fail, 0);
      if (m_prev_stall) begin
         chk(chk_valid == m_vld, "R3 chk_valid held", chk_valid, m_vld);
      end else if (mb) begin
         chk(chk_valid == m_vld, "R5 chk_valid masked", chk_valid, m_vld);
      end else begin
         chk(chk_valid == m_vld, "R2 chk_valid", chk_valid, m_vld);
      end
      chk(chk_err == (m_vld && m_err), "R2 chk_err", chk_err, m_vld && m_err);
   endtask

   task automatic step();
      @(negedge clk);
      if (rst_n) compare_all();
   endtask

   task automatic drive_core(int i, bit v);
      logic [15:0] r;
      core_valid = v;
      core_op    = 3'(i % 8);
      core_a     = rnd();
      core_b     = rnd();
      r          = ref_alu(i % 8, core_a, core_b);
      core_pred  = (i % 3 == 0) ? (r ^ 16'h0004) : r;
   endtask

   task automatic run_test(int stall_mod, bit junk);
      int guard;
      start = 1'b1;
      step();
      start = 1'b0;
      guard = 0;
      while (m_state != S_FIN && guard < 2000) begin
         stall = (stall_mod != 0) && (guard % stall_mod == 1);
         // R6: stray start pulses while busy
         start = (guard == 5) || (guard == 40);
         if (junk) drive_core(guard, 1'b1);
         guard++;
         step();
      end
      start = 1'b0; stall = 1'b0; core_valid = 1'b0;
      chk(guard < 2000, "R4 run completes", guard, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !fail && !mem_fail && !chk_valid && fail_idx == 0,
          "R1 reset", {busy, done, fail, mem_fail, chk_valid}, 0);

      // R2, R3 normal checking with stalls
      for (int i = 0; i < 48; i++) begin
         drive_core(i, (i % 5) != 4);
         stall = (i % 7 == 3) || (i % 11 == 6);
         step();
      end
      stall = 1'b0; core_valid = 1'b0;
      step();

      // R4, R5, R6, R7, R8 self-test with junk core traffic
      run_test(0, 1'b1);
      chk(done == 1'b1, "R4 done after run", done, 1);
      chk(fail == 1'b0, "R7 no vector failure", fail, 0);
      chk(mem_fail == 1'b0, "R8 march clean", mem_fail, 0);
      repeat (4) step();
      chk(done == 1'b1, "R9 done held", done, 1);

      // R9 restart from done, stalled vector phase
      run_test(3, 1'b0);
      chk(done == 1'b1, "R9 rerun done", done, 1);
      chk(fail == 1'b0, "R7 rerun fail", fail, 0);

      // R2 normal traffic after test
      for (int i = 0; i < 16; i++) begin
         drive_core(i + 1, 1'b1);
         step();
      end
      core_valid = 1'b0;
      step();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule